// File: doc/BRIEF.md
# Privileged Quantum Timer

This block is a countdown timer that lets the operating system take back the processor from a user program at the end of a time slice. Supervisor code loads a start count. A fixed-rate tick pulse then decrements the count by one. When the count reaches zero, the block latches an interrupt request. The request stays raised until the interrupt handler acknowledges it.

Writing the count is a privileged operation. A load request made while the mode input shows user mode does not reach the counter. The block answers it with a one-cycle trap pulse, so the processor can raise an illegal-operation exception. The current count can always be read on an output.

Top module: `quantum_timer`

## Requirements
- R1: Each cycle with `tick` high decrements `count` by one while `count` is non-zero and no valid load happens in that cycle. The new value is visible after that clock edge.
- R2: A tick that brings an armed count down to zero sets `irq` at the same clock edge at which `count` becomes 0.
- R3: A load with `mode_user` = 0 (supervisor) writes `load_val` into `count` at the next edge and arms the timer.
- R4: A load with `mode_user` = 1 (user) leaves `count` untouched. It produces `trap` high for exactly one cycle, starting at the next edge. A tick in the same cycle still decrements.
- R5: `irq` stays high until a cycle with `irq_ack` high. An acknowledge in the same cycle as a new expiry leaves `irq` set.
- R6: Once at zero, `count` holds at 0 and does not wrap. Further ticks do not raise `irq` again until a new supervisor load.
- R7: A supervisor load of 0 arms the timer, and the next tick sets `irq`.
- R8: When a supervisor load and a tick arrive in the same cycle, the load wins: `count` takes `load_val` and no expiry happens.
- R9: While `rst_n` is low, and after it is released, `count` is 0 and `irq` and `trap` are low. The timer starts disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Request to write a new start count |
| load_val | input | CNT_W | Start count to load |
| mode_user | input | 1 | Current privilege mode: 0 supervisor, 1 user |
| tick | input | 1 | Single-cycle fixed-rate tick pulse, synchronous to clk |
| irq_ack | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Sticky timer interrupt request |
| trap | output | 1 | One-cycle pulse on a user-mode load attempt |
| count | output | CNT_W | Current count |

## Verification
The bench loads every value of a 4-bit counter and ticks until after expiry. It confirms that `irq` rises on tick max(N,1) and at no other tick. An off-by-one on the zero compare would fire one tick early or late. A missing disarm would fire again, or wrap to 15, on the extra ticks after zero. The bench also sets up the collisions: a load against a tick, where a reversed priority leaves N-1 or raises a stray interrupt; and an acknowledge against an expiry, where a clear-first latch loses the interrupt. User-mode loads are checked for an unchanged count and a trap pulse that lasts exactly one cycle.

// File: rtl/qt_pkg.sv
package qt_pkg;
    localparam int unsigned QT_DEFAULT_W = 16;

    typedef struct packed {
        logic pend;
    } irq_state_t;

    typedef struct packed {
        logic trap;
    } gate_state_t;
endpackage

// File: rtl/qt_priv_gate.sv
module qt_priv_gate
    import qt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_req,
    input  logic mode_user,
    output logic ld_valid,
    output logic trap
);
    gate_state_t s_d, s_q;

    always_comb begin
        ld_valid = load_req & ~mode_user;
        s_d      = '0;
        s_d.trap = load_req & mode_user;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trap = s_q.trap;

    // R4: a user-mode attempt yields a trap in the following cycle
    p_user_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && mode_user) |=> trap);
    // R4: a trap is never raised without a user-mode attempt
    p_trap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(load_req && mode_user)) |=> !trap);
endmodule

// File: rtl/qt_counter.sv
module qt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (ld_valid) begin
            s_d.cnt   = ld_val;
            s_d.armed = 1'b1;
        end else if (tick && s_q.armed) begin
            if (s_q.cnt == '0 || s_q.cnt == ONE) begin
                s_d.cnt   = '0;
                s_d.armed = 1'b0;
                expire    = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end else if (tick && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

    // R1: tick without a load steps the count down by one
    p_step_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_valid && count != '0) |=> count == $past(count) - ONE);
    // R3 / R8: a valid load always lands, even against a tick
    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> count == $past(ld_val));
    // R6: zero is held until reloaded
    p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !ld_valid) |=> count == '0);
    // R6: no expiry without a tick, and none against a load
    p_expire_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (tick && !ld_valid));
endmodule

// File: rtl/qt_irq_latch.sv
module qt_irq_latch
    import qt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_ack,
    output logic irq
);
    irq_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.pend = expire | (s_q.pend & ~irq_ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.pend;

    // R5: request is sticky without acknowledge
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);
    // R5: a fresh expiry survives a same-cycle acknowledge
    p_ack_race_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);
endmodule

// File: rtl/quantum_timer.sv
module quantum_timer
    import qt_pkg::*;
#(
    parameter int unsigned CNT_W = QT_DEFAULT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic             mode_user,
    input  logic             tick,
    input  logic             irq_ack,
    output logic             irq,
    output logic             trap,
    output logic [CNT_W-1:0] count
);
    logic ld_valid;
    logic expire;

    qt_priv_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .mode_user(mode_user),
        .ld_valid (ld_valid),
        .trap     (trap)
    );

    qt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_valid(ld_valid),
        .ld_val  (load_val),
        .tick    (tick),
        .count   (count),
        .expire  (expire)
    );

    qt_irq_latch u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .irq_ack(irq_ack),
        .irq    (irq)
    );

    // R4: user-mode load without tick leaves the count as it was
    p_user_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && mode_user && !tick) |=> count == $past(count));
    // R2: the interrupt only rises together with a zero count
    p_irq_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> count == '0);
endmodule

// File: tb/quantum_timer_tb_top.sv
`timescale 1ns/1ps
module quantum_timer_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_req = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         mode_user = 1'b0;
    logic         tick = 1'b0;
    logic         irq_ack = 1'b0;
    logic         irq, trap;
    logic [W-1:0] count;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    quantum_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_val(load_val),
        .mode_user(mode_user), .tick(tick), .irq_ack(irq_ack),
        .irq(irq), .trap(trap), .count(count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive inputs for one cycle, land on the next negedge
    task automatic cyc(input bit ld, input bit usr, input int val,
                       input bit tk, input bit ak);
        load_req  = ld;
        mode_user = usr;
        load_val  = W'(val);
        tick      = tk;
        irq_ack   = ak;
        @(negedge clk);
        load_req = 1'b0; tick = 1'b0; irq_ack = 1'b0; mode_user = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 count in reset", count, 0);
        chk("R9 irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 count after reset", count, 0);
        chk("R9 irq after reset", irq, 0);
        chk("R9 trap after reset", trap, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R9 disarmed tick no irq", irq, 0);
        chk("R6 disarmed zero holds", count, 0);

        // sweep all start values
        for (int n = 0; n < (1 << W); n++) begin
            int fire;
            fire = (n == 0) ? 1 : n;
            cyc(1, 0, n, 0, 0);
            chk("R3 supervisor load value", count, n);
            chk("R3 no irq at load", irq, 0);
            for (int k = 1; k <= fire + 2; k++) begin
                int expc;
                expc = (n - k > 0) ? n - k : 0;
                cyc(0, 0, 0, 1, 0);
                cyc(0, 0, 0, 0, 0);
                chk(n == 0 ? "R7 count on tick" : "R1 count on tick", count, expc);
                chk(k > fire ? "R6 irq stays latched" :
                    (n == 0 ? "R7 irq after zero load" : "R2 irq at zero"),
                    irq, (k >= fire) ? 1 : 0);
            end
            cyc(0, 0, 0, 0, 1);
            chk("R5 ack clears irq", irq, 0);
            cyc(0, 0, 0, 1, 0);
            chk("R6 no refire at zero", irq, 0);
            chk("R6 no wrap", count, 0);
        end

        // privilege check
        cyc(1, 0, 9, 0, 0);
        cyc(1, 1, 3, 0, 0);
        chk("R4 user load ignored", count, 9);
        chk("R4 trap pulse", trap, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R4 trap one cycle", trap, 0);
        cyc(1, 1, 2, 1, 0);
        chk("R4 tick still counts", count, 8);
        chk("R4 trap with tick", trap, 1);
        cyc(1, 0, 12, 0, 0);
        chk("R4 supervisor no trap", trap, 0);

        // load against tick
        cyc(1, 0, 5, 1, 0);
        chk("R8 load beats tick", count, 5);
        cyc(1, 0, 1, 1, 0);
        chk("R8 no expiry on load", irq, 0);
        chk("R8 count one", count, 1);

        // ack against expiry
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R7 zero load fires", irq, 1);
        cyc(1, 0, 1, 0, 0);
        chk("R5 irq held across load", irq, 1);
        cyc(0, 0, 0, 1, 1);
        chk("R5 ack with expiry keeps irq", irq, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R5 still held", irq, 1);
        cyc(0, 0, 0, 0, 1);
        chk("R5 ack clears", irq, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule